// File: doc/BRIEF.md
# Byte-Wide Host Port Slave

This block lets an external host processor reach a 16-bit on-chip memory through an 8-bit data path. The host sees three registers: a control register, an address register and a data register. It picks one with a 2-bit select code and picks the upper or lower byte of the word with a byte-half line. A read/write line sets the direction of the transfer. Each 16-bit word therefore takes two byte strobes, and the upper byte always goes first.

The host strobes and chip select are asynchronous to the internal clock. Each one passes through a synchronizer, and edges are detected on the synchronized copies. The select, byte-half and direction inputs are captured when the effective data strobe falls. An optional address strobe can capture them earlier instead. Writing the second byte of a data-register word starts one memory write at the address held in the address register. Reading the first byte of the data register fetches the word from memory.

Top module: `host_port`

## Requirements
- R1: After reset, `hd_oe`, `hd_out`, `mem_we` and `mem_re` are all 0. The control and address registers read back as 0x0000.
- R2: Select code 2'b00 reaches the control register and 2'b10 reaches the address register. Codes 2'b01 and 2'b11 both reach the data register and behave the same way.
- R3: For the control and address registers, `hbyte`=0 reads or writes bits 15:8 and `hbyte`=1 reads or writes bits 7:0. The other half is left unchanged.
- R4: A data-register write with `hbyte`=0 only stores that byte and does not touch memory. The following write with `hbyte`=1 raises `mem_we` for exactly one cycle. During that cycle `mem_wdata` is {first byte, second byte} and `mem_addr` is the address register.
- R5: A data-register read with `hbyte`=0 raises `mem_re` for exactly one cycle at the address register and returns bits 15:8 of that word. A following read with `hbyte`=1 returns bits 7:0 of the same fetched word and starts no memory read.
- R6: The data strobe is active only when `hcs_n` is low and exactly one of `hds1_n` and `hds2_n` is low. Either strobe line can carry an access. If both strobe lines are low, or if `hcs_n` is high, no register or memory changes.
- R7: `hsel`, `hbyte`, `hrnw` and `hd_in` are taken at the falling edge of the effective strobe. Changes on these inputs later in the same strobe have no effect.
- R8: When the address strobe `has_n` falls with chip select low, the control inputs are captured at that moment. The next data strobe then uses these captured values instead of the live pins. The capture is released when that data strobe ends.
- R9: `hd_oe` rises only during a read access. It returns to 0 within three clocks after the strobe is released.
- R10: Only the low AW bits of the 16-bit address register drive `mem_addr`. The upper bits are stored and read back but do not select memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| hcs_n | input | 1 | Chip select, active low |
| hds1_n | input | 1 | Data strobe 1, active low |
| hds2_n | input | 1 | Data strobe 2, active low |
| has_n | input | 1 | Address strobe, active low (tie high when unused) |
| hsel | input | 2 | Register select code |
| hbyte | input | 1 | Byte half: 0 = upper byte, 1 = lower byte |
| hrnw | input | 1 | 1 = read, 0 = write |
| hd_in | input | 8 | Host write data |
| hd_out | output | 8 | Host read data |
| hd_oe | output | 1 | Read data valid / drive enable |
| mem_addr | output | AW | Memory word address |
| mem_we | output | 1 | Memory write pulse |
| mem_re | output | 1 | Memory read pulse |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after `mem_re` |

## Verification
The bench builds the port with AW = 6, so the memory has only 64 words. This makes the address register wider than the memory address. An address such as 0x0041 then shows whether the upper bits are dropped at `mem_addr` while still being kept in the register itself. Synchronizer depth stays at its default of two stages. This fixes the delay from strobe to action, so the bench can hold each strobe for a fixed number of clocks.

// File: rtl/hp_pkg.sv
package hp_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'b00,
    SEL_DATA_B = 2'b01,
    SEL_ADDR   = 2'b10,
    SEL_DATA   = 2'b11
  } hp_sel_e;

  typedef struct packed {
    logic [1:0] sel;
    logic       half;
    logic       rnw;
  } hp_ctl_t;

endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= RST_VAL;
        else     chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= RST_VAL;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/hp_strobe.sv
module hp_strobe
  import hp_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    cs_n_s,
  input  logic    ds1_n_s,
  input  logic    ds2_n_s,
  input  logic    as_n_s,
  input  hp_ctl_t ctl_live,
  output logic    ds_act,
  output logic    ds_fall,
  output logic    ds_rise,
  output hp_ctl_t ctl_lat
);

  logic    act_q, as_act, as_q, as_valid;
  hp_ctl_t as_hold;

  assign ds_act  = ~cs_n_s & (ds1_n_s ^ ds2_n_s);
  assign as_act  = ~cs_n_s & ~as_n_s;
  assign ds_fall = ds_act & ~act_q;
  assign ds_rise = ~ds_act & act_q;
  assign ctl_lat = as_valid ? as_hold : ctl_live;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= 1'b0;
      as_q     <= 1'b0;
      as_valid <= 1'b0;
      as_hold  <= '0;
    end else begin
      act_q <= ds_act;
      as_q  <= as_act;
      if (ds_rise) as_valid <= 1'b0;
      if (as_act && !as_q) begin
        as_hold  <= ctl_live;
        as_valid <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/hp_regs.sv
module hp_regs
  import hp_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 16,
  localparam int BW = DW / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ds_fall,
  input  logic          ds_rise,
  input  hp_ctl_t       ctl,
  input  logic [BW-1:0] wbyte,
  input  logic [DW-1:0] mem_rdata,
  output logic [BW-1:0] hd_out,
  output logic          hd_oe,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [DW-1:0] mem_wdata
);

  logic [DW-1:0] ctrl_q, addr_q, rd_word;
  logic [BW-1:0] wr_hi;
  logic          rd_stage;
  logic          is_data;

  assign is_data  = ctl.sel[0];
  assign mem_addr = addr_q[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      addr_q    <= '0;
      rd_word   <= '0;
      wr_hi     <= '0;
      rd_stage  <= 1'b0;
      hd_out    <= '0;
      hd_oe     <= 1'b0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      mem_wdata <= '0;
    end else begin
      mem_we   <= 1'b0;
      mem_re   <= 1'b0;
      rd_stage <= mem_re;
      if (rd_stage) begin
        rd_word <= mem_rdata;
        hd_out  <= mem_rdata[DW-1:BW];
      end
      if (ds_rise) hd_oe <= 1'b0;
      if (ds_fall) begin
        if (ctl.rnw) begin
          hd_oe <= 1'b1;
          if (is_data) begin
            if (!ctl.half) mem_re <= 1'b1;
            else           hd_out <= rd_word[BW-1:0];
          end else if (ctl.sel == SEL_ADDR) begin
            hd_out <= ctl.half ? addr_q[BW-1:0] : addr_q[DW-1:BW];
          end else begin
            hd_out <= ctl.half ? ctrl_q[BW-1:0] : ctrl_q[DW-1:BW];
          end
        end else begin
          if (is_data) begin
            if (!ctl.half) begin
              wr_hi <= wbyte;
            end else begin
              mem_we    <= 1'b1;
              mem_wdata <= {wr_hi, wbyte};
            end
          end else if (ctl.sel == SEL_ADDR) begin
            if (ctl.half) addr_q[BW-1:0]  <= wbyte;
            else          addr_q[DW-1:BW] <= wbyte;
          end else begin
            if (ctl.half) ctrl_q[BW-1:0]  <= wbyte;
            else          ctrl_q[DW-1:BW] <= wbyte;
          end
        end
      end
    end
  end

endmodule

// File: rtl/host_port.sv
module host_port
  import hp_pkg::*;
#(
  parameter int AW      = 10,
  parameter int SYNC_ST = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hcs_n,
  input  logic          hds1_n,
  input  logic          hds2_n,
  input  logic          has_n,
  input  logic [1:0]    hsel,
  input  logic          hbyte,
  input  logic          hrnw,
  input  logic [7:0]    hd_in,
  output logic [7:0]    hd_out,
  output logic          hd_oe,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata
);

  localparam int NSYNC = 4;

  logic [NSYNC-1:0] raw_n, sync_n;
  logic             ds_act, ds_fall, ds_rise;
  hp_ctl_t          ctl_live, ctl_lat;

  assign raw_n    = {hcs_n, hds1_n, hds2_n, has_n};
  assign ctl_live = '{sel: hsel, half: hbyte, rnw: hrnw};

  hp_sync #(.W(NSYNC), .STAGES(SYNC_ST), .RST_VAL('1)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_n),
    .q   (sync_n)
  );

  hp_strobe i_strobe (
    .clk      (clk),
    .rst      (rst),
    .cs_n_s   (sync_n[3]),
    .ds1_n_s  (sync_n[2]),
    .ds2_n_s  (sync_n[1]),
    .as_n_s   (sync_n[0]),
    .ctl_live (ctl_live),
    .ds_act   (ds_act),
    .ds_fall  (ds_fall),
    .ds_rise  (ds_rise),
    .ctl_lat  (ctl_lat)
  );

  hp_regs #(.AW(AW), .DW(16)) i_regs (
    .clk       (clk),
    .rst       (rst),
    .ds_fall   (ds_fall),
    .ds_rise   (ds_rise),
    .ctl       (ctl_lat),
    .wbyte     (hd_in),
    .mem_rdata (mem_rdata),
    .hd_out    (hd_out),
    .hd_oe     (hd_oe),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_wdata (mem_wdata)
  );

endmodule

// File: rtl/host_port_chk.sv
module host_port_chk (
  input logic clk,
  input logic rst,
  input logic ds_act,
  input logic hd_oe,
  input logic mem_we,
  input logic mem_re
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!hd_oe && !mem_we && !mem_re));

  a_r4_write_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  a_r5_read_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> !mem_re);

  a_r6_write_needs_strobe: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(ds_act));

  a_r9_oe_release: assert property (@(posedge clk) disable iff (rst)
    $fell(ds_act) |=> !hd_oe);

endmodule

bind host_port host_port_chk i_chk (
  .clk    (clk),
  .rst    (rst),
  .ds_act (ds_act),
  .hd_oe  (hd_oe),
  .mem_we (mem_we),
  .mem_re (mem_re)
);

// File: tb/test_host_port.sv
module test_host_port;

  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hcs_n = 1'b1, hds1_n = 1'b1, hds2_n = 1'b1, has_n = 1'b1;
  logic [1:0]    hsel = 2'b00;
  logic          hbyte = 1'b0, hrnw = 1'b0;
  logic [7:0]    hd_in = 8'h00;
  logic [7:0]    hd_out;
  logic          hd_oe;
  logic [AW-1:0] mem_addr;
  logic          mem_we, mem_re;
  logic [15:0]   mem_wdata, mem_rdata;

  logic [15:0]   ram [DEPTH];
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;
  logic [31:0]   wq [$];
  logic [15:0]   rq [$];
  logic [15:0]   m_addr = 16'h0000;
  logic          last_oe;

  always #5 clk = ~clk;

  host_port #(.AW(AW)) i_host_port (
    .clk, .rst, .hcs_n, .hds1_n, .hds2_n, .has_n, .hsel, .hbyte, .hrnw,
    .hd_in, .hd_out, .hd_oe, .mem_addr, .mem_we, .mem_re, .mem_wdata,
    .mem_rdata
  );

  initial for (int i = 0; i < DEPTH; i++) ram[i] = 16'h0000;

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= ram[mem_addr];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model: every memory strobe is matched against the queue of expected ones.
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_we) begin
        if (wq.size() == 0) chk("R4 unexpected mem_we", {16'(mem_addr), mem_wdata}, 32'hxxxx_xxxx);
        else chk("R4/R10 write addr,data", {16'(mem_addr), mem_wdata}, wq.pop_front());
      end
      if (mem_re) begin
        if (rq.size() == 0) chk("R5 unexpected mem_re", 32'(mem_addr), 32'hxxxx_xxxx);
        else chk("R5/R10 read addr", 32'(mem_addr), 32'(rq.pop_front()));
      end
    end
  end

  task automatic acc(input logic [1:0] s, input logic b, input logic r, input logic [7:0] d,
                     input int which, input bit chg, output logic [7:0] q);
    @(negedge clk);
    hsel = s; hbyte = b; hrnw = r; hd_in = d;
    if (which != 2) hds1_n = 1'b0;
    if (which != 1) hds2_n = 1'b0;
    repeat (5) @(negedge clk);
    if (chg) begin hsel = ~s; hbyte = ~b; hd_in = ~d; end
    repeat (3) @(negedge clk);
    q = hd_out;
    last_oe = hd_oe;
    hds1_n = 1'b1; hds2_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic wr_word(input logic [1:0] s, input logic [15:0] w, input int which);
    logic [7:0] q;
    acc(s, 1'b0, 1'b0, w[15:8], which, 1'b0, q);
    if (s == 2'b10) m_addr = w;
    if (s[0]) wq.push_back({16'(m_addr[AW-1:0]), w});
    acc(s, 1'b1, 1'b0, w[7:0], which, 1'b0, q);
  endtask

  task automatic rd_word(input logic [1:0] s, output logic [15:0] w);
    logic [7:0] hi, lo;
    if (s[0]) rq.push_back(16'(m_addr[AW-1:0]));
    acc(s, 1'b0, 1'b1, 8'h00, 1, 1'b0, hi);
    acc(s, 1'b1, 1'b1, 8'h00, 1, 1'b0, lo);
    w = {hi, lo};
  endtask

  initial begin
    logic [15:0] w;
    logic [7:0]  q;
    repeat (5) @(negedge clk);
    chk("R1 hd_oe after reset", 32'(hd_oe), 0);
    chk("R1 hd_out after reset", 32'(hd_out), 0);
    chk("R1 mem strobes after reset", {mem_we, mem_re}, 0);
    rst = 1'b0;
    hcs_n = 1'b0;
    repeat (3) @(negedge clk);
    rd_word(2'b00, w); chk("R1 control reads zero", 32'(w), 0);
    rd_word(2'b10, w); chk("R1 address reads zero", 32'(w), 0);

    wr_word(2'b00, 16'hA55A, 1);
    rd_word(2'b00, w); chk("R2 control readback", 32'(w), 32'hA55A);
    acc(2'b00, 1'b1, 1'b1, 8'h00, 1, 1'b0, q);
    chk("R3 low half alone", 32'(q), 32'h5A);
    chk("R9 hd_oe during read", 32'(last_oe), 1);
    chk("R9 hd_oe after release", 32'(hd_oe), 0);
    acc(2'b00, 1'b0, 1'b0, 8'hC3, 1, 1'b0, q);
    chk("R9 hd_oe during write", 32'(last_oe), 0);
    rd_word(2'b00, w); chk("R3 upper-half write keeps lower", 32'(w), 32'hC35A);

    wr_word(2'b10, 16'h0012, 1);
    rd_word(2'b10, w); chk("R2 address readback", 32'(w), 32'h0012);
    wr_word(2'b11, 16'hBEEF, 1);
    chk("R4 memory word code 11", 32'(ram[18]), 32'hBEEF);
    rd_word(2'b11, w); chk("R5 data read code 11", 32'(w), 32'hBEEF);

    wr_word(2'b10, 16'h0013, 1);
    wr_word(2'b01, 16'h1234, 1);
    rd_word(2'b01, w); chk("R2 data via code 01", 32'(w), 32'h1234);
    rd_word(2'b11, w); chk("R2 code 11 same word", 32'(w), 32'h1234);

    wr_word(2'b10, 16'h0014, 1);
    acc(2'b11, 1'b0, 1'b0, 8'h77, 1, 1'b0, q);
    chk("R4 first byte no write", 32'(ram[20]), 0);
    wq.push_back({16'h0014, 16'h7788});
    acc(2'b11, 1'b1, 1'b0, 8'h88, 1, 1'b0, q);
    chk("R4 second byte writes", 32'(ram[20]), 32'h7788);

    wr_word(2'b10, 16'h0015, 2);
    wr_word(2'b11, 16'hCAFE, 2);
    rd_word(2'b11, w); chk("R6 write via strobe 2", 32'(w), 32'hCAFE);
    acc(2'b11, 1'b0, 1'b0, 8'h11, 1, 1'b0, q);
    acc(2'b11, 1'b1, 1'b0, 8'h22, 3, 1'b0, q);
    chk("R6 both strobes low ignored", 32'(ram[21]), 32'hCAFE);
    hcs_n = 1'b1;
    acc(2'b00, 1'b0, 1'b0, 8'hFF, 1, 1'b0, q);
    hcs_n = 1'b0;
    repeat (3) @(negedge clk);
    rd_word(2'b00, w); chk("R6 chip select high ignored", 32'(w), 32'hC35A);

    acc(2'b00, 1'b0, 1'b0, 8'h11, 1, 1'b1, q);
    rd_word(2'b00, w); chk("R7 control latched at fall", 32'(w), 32'h115A);
    rd_word(2'b10, w); chk("R7 address untouched", 32'(w), 32'h0015);

    @(negedge clk);
    hsel = 2'b00; hbyte = 1'b1; hrnw = 1'b0; hd_in = 8'h3C;
    has_n = 1'b0;
    repeat (5) @(negedge clk);
    has_n = 1'b1;
    hsel = 2'b10; hbyte = 1'b0;
    repeat (2) @(negedge clk);
    hds1_n = 1'b0;
    repeat (8) @(negedge clk);
    hds1_n = 1'b1;
    repeat (5) @(negedge clk);
    rd_word(2'b00, w); chk("R8 address-strobe capture", 32'(w), 32'h113C);
    rd_word(2'b10, w); chk("R8 live pins not used", 32'(w), 32'h0015);

    wr_word(2'b10, 16'h0041, 1);
    wr_word(2'b11, 16'h5151, 1);
    chk("R10 upper address bits dropped", 32'(ram[1]), 32'h5151);
    rd_word(2'b10, w); chk("R10 address register keeps all bits", 32'(w), 32'h0041);
    rd_word(2'b11, w); chk("R10 data read wraps", 32'(w), 32'h5151);

    chk("R4/R5 all expected strobes seen", wq.size() + rq.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
      end
      wait (done);
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule